// File: doc/BRIEF.md
# Multiplexed 16-bit Peripheral Bus Master

This block turns single 32-bit read or write requests from an internal port into a sequence of cycles on a shared 16-bit external address/data bus. It is meant to control microcontroller-style peripherals or FIFO-style devices. The internal side offers a request with a direction, a 16-bit address and a 32-bit write word, using a valid/ready handshake. Once the transfer finishes, the block gives a one-cycle completion pulse, an error flag and, for reads, the assembled 32-bit word. Only one transfer can be in flight at a time.

A mode input chooses how each request is placed on the bus. In address mode, one address cycle marked by an address-latch strobe comes first, followed by two data cycles. In FIFO mode there is no address, only the two data cycles. Each data cycle is framed by an active-low read or write strobe. It lasts at least two clocks and is extended until the peripheral's ready input is seen high. If ready never arrives, a timeout ends the transfer with an error. The bus is split into output, output-enable and input vectors so the pad ring can build the tri-state driver.

Top module: `pbus_master`

## Requirements
- R1: After reset, req_ready=1, ale=0, rd_n=1, wr_n=1, bus_oe=0 and done=0.
- R2: With mode_fifo=0 captured, a transfer begins with exactly one clock of ale=1, in which bus_oe=1, both strobes are high and bus_out equals the request address. This comes before the first data cycle.
- R3: With mode_fifo=1 captured, ale is never asserted, and the transfer consists of exactly two data cycles.
- R4: On a write, bus_oe=1 while wr_n=0. bus_out carries write data bits 15:0 in the first data cycle and bits 31:16 in the second.
- R5: On a read, bus_oe=0 while rd_n=0. bus_in is sampled at the rising edge where bus_rdy is seen high, and rd_data with done equals {second-cycle sample, first-cycle sample}.
- R6: Each data cycle holds its strobe low for at least 2 clocks and ends at the first edge, from the second clock on, at which bus_rdy=1. A peripheral that raises ready after N low clocks therefore sees max(2, N+1) low clocks. Both strobes are high for exactly one clock between the two data cycles.
- R7: If bus_rdy is not seen within TIMEOUT clocks of a data cycle, the strobe is released after exactly TIMEOUT low clocks. The transfer then ends with done=1 and done_err=1, no further data cycle follows, and a read returns rd_data=0.
- R8: done is a one-clock pulse in the clock after the last data cycle, with done_err=0 when the transfer completed normally. req_ready is 0 from the clock after acceptance until that pulse.
- R9: The mode is captured when the request is accepted. A change of mode_fifo during a transfer has no effect on that transfer.
- R10: The read and write strobes are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_fifo | input | 1 | 1: data-only FIFO mode, 0: address-then-data mode |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | 16 | Peripheral address |
| req_wdata | input | 32 | Write word |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Timeout flag, valid with done |
| rd_data | output | 32 | Read word, valid with done |
| bus_out | output | 16 | Outgoing bus value |
| bus_oe | output | 1 | Bus driver enable |
| bus_in | input | 16 | Incoming bus value |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_rdy | input | 1 | Peripheral ready, ends a data cycle |

## Verification
The assertions assume that req_valid is raised only while the internal side follows the handshake, and that bus_rdy and bus_in settle between clock edges. They also assume the peripheral never needs more than TIMEOUT clocks before the strobe must be released. The bench peripheral model changes bus_rdy and bus_in only at the falling clock edge. It raises ready only while a strobe is low and after a programmed number of low clocks, and it offers a request only while req_ready is high, leaving it for exactly one edge.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_GAP  = 2'd3
  } pbus_state_e;
endpackage

// File: rtl/pbus_wait_timer.sv
module pbus_wait_timer #(
  parameter int MIN_CYC = 2,
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic min_met,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] MIN_LAST = CW'(MIN_CYC - 1);
  localparam logic [CW-1:0] TO_LAST  = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (start)        cnt <= '0;
    else if (cnt != TO_LAST) cnt <= cnt + 1'b1;
  end

  assign min_met = (cnt >= MIN_LAST);
  assign expired = (cnt >= TO_LAST);
endmodule

// File: rtl/pbus_rd_capture.sv
module pbus_rd_capture #(
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_lo,
  input  logic          cap_hi,
  input  logic          cap_clr,
  input  logic [BW-1:0] bus_in,
  output logic [2*BW-1:0] word
);
  logic [BW-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      word <= '0;
    end else begin
      if (cap_lo)  lo_q <= bus_in;
      if (cap_hi)  word <= {bus_in, lo_q};
      else if (cap_clr) word <= '0;
    end
  end
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_fifo,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [2*BW-1:0] req_wdata,
  input  logic          bus_rdy,
  input  logic          min_met,
  input  logic          expired,
  output logic          req_ready,
  output logic          tmr_start,
  output logic          cap_lo,
  output logic          cap_hi,
  output logic          cap_clr,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          bus_oe,
  output logic [BW-1:0] bus_out,
  output logic          done,
  output logic          done_err
);
  pbus_state_e st, st_n;
  logic          beat, beat_n;
  logic          wr_q;
  logic [2*BW-1:0] wd_q;

  logic accept, cyc_ok, cyc_to, nxt_write;
  logic [2*BW-1:0] nxt_wd;
  logic [BW-1:0]   nxt_out;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign cyc_ok    = (st == ST_DATA) && bus_rdy && min_met;
  assign cyc_to    = (st == ST_DATA) && !cyc_ok && expired;
  assign nxt_write = accept ? req_write : wr_q;
  assign nxt_wd    = accept ? req_wdata : wd_q;

  always_comb begin
    st_n   = st;
    beat_n = beat;
    unique case (st)
      ST_IDLE: if (accept) begin
        st_n   = mode_fifo ? ST_DATA : ST_ADDR;
        beat_n = 1'b0;
      end
      ST_ADDR: st_n = ST_DATA;
      ST_DATA: begin
        if (cyc_to)      st_n = ST_IDLE;
        else if (cyc_ok) st_n = beat ? ST_IDLE : ST_GAP;
      end
      ST_GAP: begin
        st_n   = ST_DATA;
        beat_n = 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_comb begin
    if (st_n == ST_ADDR) nxt_out = BW'(req_addr);
    else if (beat_n)     nxt_out = nxt_wd[2*BW-1:BW];
    else                 nxt_out = nxt_wd[BW-1:0];
  end

  assign tmr_start = (st_n == ST_DATA) && (st != ST_DATA);
  assign cap_lo    = cyc_ok && !beat && !wr_q;
  assign cap_hi    = cyc_ok && beat && !wr_q;
  assign cap_clr   = cyc_to && !wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      beat     <= 1'b0;
      wr_q     <= 1'b0;
      wd_q     <= '0;
      ale      <= 1'b0;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      bus_oe   <= 1'b0;
      bus_out  <= '0;
      done     <= 1'b0;
      done_err <= 1'b0;
    end else begin
      st       <= st_n;
      beat     <= beat_n;
      wr_q     <= nxt_write;
      wd_q     <= nxt_wd;
      ale      <= (st_n == ST_ADDR);
      rd_n     <= !((st_n == ST_DATA) && !nxt_write);
      wr_n     <= !((st_n == ST_DATA) && nxt_write);
      bus_oe   <= (st_n == ST_ADDR) || ((st_n == ST_DATA) && nxt_write);
      bus_out  <= nxt_out;
      done     <= cyc_to || (cyc_ok && beat);
      done_err <= cyc_to;
    end
  end
endmodule

// File: rtl/pbus_master.sv
module pbus_master #(
  parameter int AW      = 16,
  parameter int BW      = 16,
  parameter int MIN_CYC = 2,
  parameter int TIMEOUT = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_fifo,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [2*BW-1:0] req_wdata,
  output logic            done,
  output logic            done_err,
  output logic [2*BW-1:0] rd_data,
  output logic [BW-1:0]   bus_out,
  output logic            bus_oe,
  input  logic [BW-1:0]   bus_in,
  output logic            ale,
  output logic            rd_n,
  output logic            wr_n,
  input  logic            bus_rdy
);
  logic tmr_start, min_met, expired;
  logic cap_lo, cap_hi, cap_clr;

  pbus_seq #(.AW(AW), .BW(BW)) u_seq (
    .clk(clk), .rst(rst), .mode_fifo(mode_fifo),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_rdy(bus_rdy), .min_met(min_met), .expired(expired),
    .req_ready(req_ready), .tmr_start(tmr_start),
    .cap_lo(cap_lo), .cap_hi(cap_hi), .cap_clr(cap_clr),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .bus_oe(bus_oe), .bus_out(bus_out),
    .done(done), .done_err(done_err)
  );

  pbus_wait_timer #(.MIN_CYC(MIN_CYC), .TIMEOUT(TIMEOUT)) u_tmr (
    .clk(clk), .rst(rst), .start(tmr_start),
    .min_met(min_met), .expired(expired)
  );

  pbus_rd_capture #(.BW(BW)) u_cap (
    .clk(clk), .rst(rst), .cap_lo(cap_lo), .cap_hi(cap_hi),
    .cap_clr(cap_clr), .bus_in(bus_in), .word(rd_data)
  );
endmodule

// File: rtl/pbus_master_chk.sv
module pbus_master_chk #(
  parameter int TIMEOUT = 16
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic done_err,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic bus_oe
);
  localparam int LW = $clog2(TIMEOUT + 2) + 1;
  logic [LW-1:0] low_run;
  logic strobe_low;

  assign strobe_low = !rd_n || !wr_n;

  always_ff @(posedge clk) begin
    if (rst)             low_run <= '0;
    else if (!strobe_low) low_run <= '0;
    else if (low_run != '1) low_run <= low_run + 1'b1;
  end

  a_r2_ale_frame: assert property (@(posedge clk) disable iff (rst)
    ale |-> (bus_oe && rd_n && wr_n));
  a_r4_write_drives: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> bus_oe);
  a_r5_read_released: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !bus_oe);
  a_r6_min_two: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_n && wr_n) |=> !(rd_n && wr_n));
  a_r7_bounded_low: assert property (@(posedge clk) disable iff (rst)
    low_run <= LW'(TIMEOUT));
  a_r7_err_with_done: assert property (@(posedge clk) disable iff (rst)
    done_err |-> done);
  a_r8_one_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
endmodule

bind pbus_master pbus_master_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .done_err(done_err), .ale(ale), .rd_n(rd_n),
  .wr_n(wr_n), .bus_oe(bus_oe)
);

// File: tb/test_pbus_master.sv
module test_pbus_master;
  localparam int TO = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_fifo = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        done, done_err;
  logic [31:0] rd_data;
  logic [15:0] bus_out;
  logic        bus_oe;
  logic [15:0] bus_in = '0;
  logic        ale, rd_n, wr_n;
  logic        bus_rdy = 1'b0;

  pbus_master #(.TIMEOUT(TO)) i_pbus_master (
    .clk(clk), .rst(rst), .mode_fifo(mode_fifo), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .done_err(done_err),
    .rd_data(rd_data), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .bus_rdy(bus_rdy)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // peripheral model and bus monitor, all at the falling edge
  int          wait_n = 0;
  logic [31:0] rword = '0;
  int          ale_cyc, dcyc, gap, done_cnt;
  int          lowlen [4];
  logic [15:0] wr_half [4];
  logic [15:0] ale_addr;
  logic        oe_bad, ale_late, done_seen, err_got, prev_low;
  logic [31:0] rd_got;

  task automatic clear_mon();
    ale_cyc = 0; dcyc = 0; gap = 0; done_cnt = 0;
    for (int i = 0; i < 4; i++) begin lowlen[i] = 0; wr_half[i] = '0; end
    ale_addr = '0; oe_bad = 1'b0; ale_late = 1'b0; done_seen = 1'b0;
    err_got = 1'b0; prev_low = 1'b0; rd_got = '0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (done) begin
        done_cnt++; done_seen = 1'b1; rd_got = rd_data; err_got = done_err;
      end
      if (ale) begin
        ale_cyc++; ale_addr = bus_out;
        if (dcyc > 0) ale_late = 1'b1;
      end
      if (!rd_n || !wr_n) begin
        if (!prev_low && dcyc < 4) dcyc++;
        if (dcyc > 0) lowlen[dcyc-1]++;
        if (!wr_n) begin
          if (dcyc > 0) wr_half[dcyc-1] = bus_out;
          if (!bus_oe) oe_bad = 1'b1;
        end
        if (!rd_n) begin
          if (bus_oe) oe_bad = 1'b1;
          bus_in = (dcyc == 1) ? rword[15:0] : rword[31:16];
        end
        bus_rdy = (lowlen[dcyc-1] > wait_n);
        prev_low = 1'b1;
      end else begin
        bus_rdy = 1'b0;
        bus_in = 16'hDEAD;
        prev_low = 1'b0;
        if (dcyc == 1 && !done_seen) gap++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_xfer(input bit fifo, input bit wr, input logic [15:0] a,
                          input logic [31:0] wd, input int wt);
    int n;
    @(negedge clk); #1;
    clear_mon();
    wait_n = wt;
    rword = fifo ? wd : {a ^ 16'hC3C3, a + 16'h0101};
    mode_fifo = fifo; req_write = wr; req_addr = a; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk); #1;
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R8 busy after accept", 32'(req_ready), 32'd0);
    n = 0;
    while (!done_seen && n < 400) begin @(negedge clk); #1; n++; end
    chk(done_seen, "R8 done arrives", 32'(done_seen), 32'd1);
    @(negedge clk); #1;
    chk(done_cnt == 1, "R8 single done", 32'(done_cnt), 32'd1);
    chk(req_ready == 1'b1, "R8 idle again", 32'(req_ready), 32'd1);
  endtask

  function automatic int exp_low(input int wt);
    return (wt + 1 > 2) ? wt + 1 : 2;
  endfunction

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
    chk(ale == 1'b0, "R1 ale", 32'(ale), 32'd0);
    chk(rd_n && wr_n, "R1 strobes", {30'd0, rd_n, wr_n}, 32'd3);
    chk(bus_oe == 1'b0, "R1 bus_oe", 32'(bus_oe), 32'd0);
    chk(done == 1'b0, "R1 done", 32'(done), 32'd0);
  endtask

  task automatic t_addr_write();
    run_xfer(1'b0, 1'b1, 16'h1A2B, 32'hCAFE_5A5A, 0);
    chk(ale_cyc == 1, "R2 one ale cycle", 32'(ale_cyc), 32'd1);
    chk(ale_addr == 16'h1A2B, "R2 address on bus", 32'(ale_addr), 32'h1A2B);
    chk(!ale_late, "R2 ale before data", 32'(ale_late), 32'd0);
    chk(dcyc == 2, "R4 two data cycles", 32'(dcyc), 32'd2);
    chk(wr_half[0] == 16'h5A5A, "R4 low half first", 32'(wr_half[0]), 32'h5A5A);
    chk(wr_half[1] == 16'hCAFE, "R4 high half second", 32'(wr_half[1]), 32'hCAFE);
    chk(!oe_bad, "R4 driver enable", 32'(oe_bad), 32'd0);
    chk(lowlen[0] == 2 && lowlen[1] == 2, "R6 minimum length",
        32'(lowlen[0] * 16 + lowlen[1]), 32'h22);
    chk(gap == 1, "R6 one idle clock between", 32'(gap), 32'd1);
    chk(!err_got, "R8 no error", 32'(err_got), 32'd0);
  endtask

  task automatic t_addr_read();
    run_xfer(1'b0, 1'b0, 16'h0F10, 32'h0, 0);
    chk(ale_cyc == 1, "R2 ale on read", 32'(ale_cyc), 32'd1);
    chk(!oe_bad, "R5 bus released on read", 32'(oe_bad), 32'd0);
    chk(rd_got == {16'h0F10 ^ 16'hC3C3, 16'h0F10 + 16'h0101}, "R5 read word",
        rd_got, {16'h0F10 ^ 16'hC3C3, 16'h0F10 + 16'h0101});
  endtask

  task automatic t_fifo_write();
    run_xfer(1'b1, 1'b1, 16'hFFFF, 32'h1357_9BDF, 1);
    chk(ale_cyc == 0, "R3 no ale in fifo mode", 32'(ale_cyc), 32'd0);
    chk(dcyc == 2, "R3 two data cycles", 32'(dcyc), 32'd2);
    chk(wr_half[0] == 16'h9BDF && wr_half[1] == 16'h1357, "R4 fifo halves",
        {wr_half[1], wr_half[0]}, 32'h1357_9BDF);
  endtask

  task automatic t_fifo_read();
    run_xfer(1'b1, 1'b0, 16'h0000, 32'h8001_7FFE, 0);
    chk(ale_cyc == 0, "R3 no ale on fifo read", 32'(ale_cyc), 32'd0);
    chk(rd_got == 32'h8001_7FFE, "R5 fifo read word", rd_got, 32'h8001_7FFE);
  endtask

  task automatic t_waits();
    for (int w = 2; w <= 6; w += 4) begin
      run_xfer(1'b0, 1'b0, 16'h4444, 32'h0, w);
      chk(lowlen[0] == exp_low(w), "R6 wait states first cycle",
          32'(lowlen[0]), 32'(exp_low(w)));
      chk(lowlen[1] == exp_low(w), "R6 wait states second cycle",
          32'(lowlen[1]), 32'(exp_low(w)));
      chk(rd_got == {16'h4444 ^ 16'hC3C3, 16'h4545}, "R5 read with waits",
          rd_got, {16'h4444 ^ 16'hC3C3, 16'h4545});
    end
  endtask

  task automatic t_timeout();
    run_xfer(1'b0, 1'b0, 16'h0BAD, 32'h0, 1000);
    chk(lowlen[0] == TO, "R7 strobe released at timeout", 32'(lowlen[0]), 32'(TO));
    chk(dcyc == 1, "R7 no second cycle", 32'(dcyc), 32'd1);
    chk(err_got, "R7 error flagged", 32'(err_got), 32'd1);
    chk(rd_got == 32'h0, "R7 read data zero", rd_got, 32'h0);
    run_xfer(1'b1, 1'b1, 16'h0, 32'hA5A5_0F0F, 0);
    chk(!err_got && dcyc == 2, "R7 recovery after timeout",
        32'(dcyc), 32'd2);
  endtask

  task automatic t_mode_change();
    @(negedge clk); #1;
    clear_mon();
    wait_n = 3; rword = '0;
    mode_fifo = 1'b0; req_write = 1'b1; req_addr = 16'h7777;
    req_wdata = 32'h1111_2222; req_valid = 1'b1;
    @(negedge clk); #1;
    req_valid = 1'b0;
    mode_fifo = 1'b1;
    for (int n = 0; n < 60 && !done_seen; n++) begin @(negedge clk); #1; end
    chk(ale_cyc == 1 && dcyc == 2, "R9 mode held during transfer",
        32'(ale_cyc * 16 + dcyc), 32'h12);
    chk(wr_half[1] == 16'h1111, "R9 data intact", 32'(wr_half[1]), 32'h1111);
    mode_fifo = 1'b0;
  endtask

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    #1; t_reset();
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_addr_write();
    t_addr_read();
    t_fifo_write();
    t_fifo_read();
    t_waits();
    t_timeout();
    t_mode_change();
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule